// File: doc/BRIEF.md
# Pseudo-Static RAM Low-Power Mode Controller

This block holds the low-power mode logic of a pseudo-static RAM. An active-low sleep pin requests low power. A sleep-select bit in a 16-bit configuration register then decides what that request does. With the bit set, the pin selects partial-array refresh, which keeps the stored data. With the bit clear, the pin leads to deep power-down, which destroys the stored data. Deep power-down is entered only after the pin has been qualified low for a minimum time. Leaving it forces a long initialization lockout.

All time windows are counted in clock cycles, derived from a clock-frequency parameter given in MHz. The block gates the array's refresh requests and the host's read and write commands. It reports ready, busy, and the current mode. A single flag marks the array contents as lost. The flag is raised on entry to deep power-down and cleared by the first write accepted afterwards. The sleep pin is assumed to be synchronous to `clk`.

Top module: `psram_lowpower_ctrl`

## Requirements
- R1: After synchronous reset, `ready`=1, `busy`=0, `in_dpd`=0, `in_par`=0, `data_invalid`=0, and `cfg_q` equals `CFG_RESET` (default 16'h0010, sleep-select bit 4 set).
- R2: While `ready`=1, `cfg_wr_en` loads `cfg_wr_data` into `cfg_q` on the next edge. Bit 4 is the sleep-select bit. A configuration write never changes the mode: `in_dpd` and `in_par` stay 0. Writes are ignored while `ready`=0.
- R3: With bit 4 = 1, a low `sleep_n` sampled while ready sets `in_par` on that edge. In this mode `rd_go`/`wr_go` stay 0, `refresh_go` follows `refresh_req`, and `data_invalid` is unchanged.
- R4: In partial-array refresh, a high `sleep_n` returns the block to `ready`=1 on the next edge. `busy` is never asserted on this path.
- R5: With bit 4 = 0, once `sleep_n` has been sampled low on QUAL_CYC+1 consecutive edges, `in_dpd` is 1 after the last of those edges. QUAL_CYC = CLK_MHZ*QUAL_US.
- R6: A low pulse sampled on QUAL_CYC or fewer edges never sets `in_dpd`. The block returns to `ready` on the first high sample, and the next low pulse is qualified from zero.
- R7: While `in_dpd`=1, `refresh_go`, `rd_go` and `wr_go` are 0 and `data_invalid` is 1.
- R8: A high `sleep_n` in deep power-down gives `busy`=1 for exactly INIT_CYC = CLK_MHZ*INIT_US cycles, with commands ignored. After that, `ready`=1.
- R9: `data_invalid` is cleared on the edge of the first write accepted after initialization. Reads leave it set.
- R10: `rd_go`/`wr_go` equal `cmd_rd`/`cmd_wr` in the same cycle when `ready`=1, and are 0 otherwise.
- R11: When a configuration write and a low `sleep_n` fall in the same cycle, the mode is chosen from the bit-4 value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_n | input | 1 | Active-low sleep request pin |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 16 | Configuration write data, bit 4 = sleep select |
| cfg_q | output | 16 | Current configuration register value |
| cmd_rd | input | 1 | Host read request |
| cmd_wr | input | 1 | Host write request |
| rd_go | output | 1 | Read forwarded to array |
| wr_go | output | 1 | Write forwarded to array |
| refresh_req | input | 1 | Refresh request from refresh timer |
| refresh_go | output | 1 | Refresh forwarded to array |
| ready | output | 1 | Normal operation, commands accepted |
| busy | output | 1 | Post-power-down initialization running |
| in_dpd | output | 1 | Deep power-down active |
| in_par | output | 1 | Partial-array refresh active |
| data_invalid | output | 1 | Array contents lost |

## Verification
Two events can land on the same edge: a configuration write that flips the sleep-select bit, and the falling sleep pin that reads that bit. The bench provokes this by driving both in one cycle in each direction, first clearing bit 4 and later setting it. It then judges which mode follows against the value held before the write. A host write on the falling-pin cycle is also checked: it must still pass, because the block is ready during that cycle.

// File: rtl/psram_lowpower_ctrl.sv
module psram_lowpower_ctrl #(
  parameter int          CLK_MHZ   = 200,
  parameter int          QUAL_US   = 10,
  parameter int          INIT_US   = 150,
  parameter int          SEL_BIT   = 4,
  parameter logic [15:0] CFG_RESET = 16'h0010
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sleep_n,
  input  logic        cfg_wr_en,
  input  logic [15:0] cfg_wr_data,
  output logic [15:0] cfg_q,
  input  logic        cmd_rd,
  input  logic        cmd_wr,
  output logic        rd_go,
  output logic        wr_go,
  input  logic        refresh_req,
  output logic        refresh_go,
  output logic        ready,
  output logic        busy,
  output logic        in_dpd,
  output logic        in_par,
  output logic        data_invalid
);
  localparam int QUAL_CYC = CLK_MHZ * QUAL_US;
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int MAX_CYC  = (INIT_CYC > QUAL_CYC) ? INIT_CYC : QUAL_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_RUN, ST_QUAL, ST_PAR, ST_DPD, ST_INIT} mode_t;

  mode_t             st;
  logic [CNT_W-1:0]  cnt;
  logic [15:0]       cfg;
  logic              lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_RUN;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: if (!sleep_n) begin
          if (cfg[SEL_BIT]) st <= ST_PAR;
          else begin
            st  <= ST_QUAL;
            cnt <= CNT_W'(1);
          end
        end
        ST_QUAL: if (sleep_n) begin
          st  <= ST_RUN;
          cnt <= '0;
        end else if (cnt == CNT_W'(QUAL_CYC)) begin
          st  <= ST_DPD;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_PAR: if (sleep_n) st <= ST_RUN;
        ST_DPD: if (sleep_n) begin
          st  <= ST_INIT;
          cnt <= '0;
        end
        ST_INIT: if (cnt == CNT_W'(INIT_CYC - 1)) begin
          st  <= ST_RUN;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        cfg <= CFG_RESET;
    else if (cfg_wr_en && ready)    cfg <= cfg_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                        lost <= 1'b0;
    else if (st == ST_DPD)          lost <= 1'b1;
    else if (st == ST_QUAL && !sleep_n && cnt == CNT_W'(QUAL_CYC)) lost <= 1'b1;
    else if (wr_go)                 lost <= 1'b0;
  end

  assign ready        = (st == ST_RUN);
  assign busy         = (st == ST_INIT);
  assign in_dpd       = (st == ST_DPD);
  assign in_par       = (st == ST_PAR);
  assign rd_go        = cmd_rd & ready;
  assign wr_go        = cmd_wr & ready;
  assign refresh_go   = refresh_req & ~in_dpd;
  assign cfg_q        = cfg;
  assign data_invalid = lost;
endmodule

// File: rtl/psram_lowpower_ctrl_chk.sv
module psram_lowpower_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sleep_n,
  input logic rd_go,
  input logic wr_go,
  input logic refresh_go,
  input logic ready,
  input logic busy,
  input logic in_dpd,
  input logic in_par,
  input logic data_invalid
);
  p_dpd_gates_r7: assert property (@(posedge clk) disable iff (rst)
    in_dpd |-> (!rd_go && !wr_go && !refresh_go && data_invalid));

  p_par_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (in_par && sleep_n) |=> (ready && !busy));

  p_dpd_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (in_dpd && sleep_n) |=> busy);

  p_dpd_from_pin_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(in_dpd) |-> $past(!sleep_n));

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (busy || in_par) |-> (!rd_go && !wr_go && !ready));

  p_modes_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ready, busy, in_dpd, in_par}));
endmodule

bind psram_lowpower_ctrl psram_lowpower_ctrl_chk i_chk (.*);

// File: tb/test_psram_lowpower_ctrl.sv
module test_psram_lowpower_ctrl;
  localparam int CLK_MHZ = 2;
  localparam int Q = CLK_MHZ * 10;
  localparam int I = CLK_MHZ * 150;

  logic clk = 0, rst = 1, sleep_n = 1, cfg_wr_en = 0, cmd_rd = 0, cmd_wr = 0, refresh_req = 0;
  logic [15:0] cfg_wr_data = '0, cfg_q;
  logic rd_go, wr_go, refresh_go, ready, busy, in_dpd, in_par, data_invalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  psram_lowpower_ctrl #(.CLK_MHZ(CLK_MHZ)) i_psram_lowpower_ctrl (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(logic [15:0] v);
    cfg_wr_data = v; cfg_wr_en = 1; tick(); cfg_wr_en = 0;
  endtask

  task automatic t_reset;
    rst = 1; tick(2); rst = 0; tick();
    chk("R1 ready", ready, 1); chk("R1 busy", busy, 0);
    chk("R1 dpd", in_dpd, 0); chk("R1 par", in_par, 0);
    chk("R1 invalid", data_invalid, 0); chk("R1 cfg", cfg_q, 16'h0010);
  endtask

  task automatic t_cfg;
    write_cfg(16'h00A5);
    chk("R2 cfg load", cfg_q, 16'h00A5);
    chk("R2 no dpd", in_dpd, 0); chk("R2 no par", in_par, 0);
    write_cfg(16'h0010);
  endtask

  task automatic t_par;
    sleep_n = 0; tick();
    chk("R3 par", in_par, 1);
    cmd_rd = 1; cmd_wr = 1; refresh_req = 1; #1;
    chk("R3 rd blocked", rd_go, 0); chk("R3 wr blocked", wr_go, 0);
    chk("R3 refresh", refresh_go, 1);
    cmd_rd = 0; cmd_wr = 0; refresh_req = 0;
    write_cfg(16'h0000);
    chk("R2 write ignored", cfg_q, 16'h0010);
    chk("R3 data kept", data_invalid, 0);
    sleep_n = 1; tick();
    chk("R4 ready", ready, 1); chk("R4 no busy", busy, 0);
  endtask

  task automatic t_short;
    write_cfg(16'h0000);
    sleep_n = 0; tick(Q);
    chk("R6 not dpd", in_dpd, 0);
    sleep_n = 1; tick();
    chk("R6 ready", ready, 1);
    sleep_n = 0; tick(Q);
    chk("R6 requalify", in_dpd, 0);
    sleep_n = 1; tick();
    chk("R6 ready again", ready, 1);
  endtask

  task automatic t_dpd;
    sleep_n = 0; tick(Q);
    chk("R5 before", in_dpd, 0);
    tick();
    chk("R5 dpd", in_dpd, 1);
    cmd_rd = 1; cmd_wr = 1; refresh_req = 1; #1;
    chk("R7 rd", rd_go, 0); chk("R7 wr", wr_go, 0);
    chk("R7 refresh", refresh_go, 0); chk("R7 invalid", data_invalid, 1);
    cmd_rd = 0; cmd_wr = 0; refresh_req = 0;
    sleep_n = 1; tick();
    chk("R8 busy start", busy, 1);
    tick(I - 1);
    chk("R8 busy end", busy, 1);
    cmd_wr = 1; #1; chk("R8 wr ignored", wr_go, 0); cmd_wr = 0;
    tick();
    chk("R8 ready", ready, 1); chk("R8 busy off", busy, 0);
    chk("R9 still invalid", data_invalid, 1);
    cmd_rd = 1; #1; chk("R10 rd pass", rd_go, 1); tick(); cmd_rd = 0;
    chk("R9 read keeps", data_invalid, 1);
    cmd_wr = 1; #1; chk("R10 wr pass", wr_go, 1); tick(); cmd_wr = 0;
    chk("R9 cleared", data_invalid, 0);
  endtask

  task automatic t_same_cycle;
    write_cfg(16'h0010);
    cfg_wr_data = 16'h0000; cfg_wr_en = 1; sleep_n = 0; cmd_wr = 1; #1;
    chk("R11 wr passes", wr_go, 1);
    tick(); cfg_wr_en = 0; cmd_wr = 0;
    chk("R11 old bit par", in_par, 1); chk("R11 cfg took", cfg_q, 16'h0000);
    sleep_n = 1; tick();
    cfg_wr_data = 16'h0010; cfg_wr_en = 1; sleep_n = 0;
    tick(); cfg_wr_en = 0;
    chk("R11 old bit qual", in_par, 0); chk("R11 not ready", ready, 0);
    sleep_n = 1; tick();
    chk("R11 back", ready, 1); chk("R11 cfg set", cfg_q, 16'h0010);
  endtask

  initial begin
    tick();
    t_reset(); t_cfg(); t_par(); t_short(); t_dpd(); t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule